// File: doc/BRIEF.md
# Multi-Site Supply-Current Sampling Sequencer

This block acquires a fixed-length series of supply-current readings from one ADC per test site while the device under test keeps running. A start command begins the series. For each sample the block sends one convert pulse to every site ADC on the same cycle. It then collects each site's result as that site reports ready and stores it in the site's own sample memory. While the series runs, the block keeps a running minimum, maximum and sum for each site.

Two pacing modes are available. In the fixed-tick mode, conversions follow a strict period of clock cycles, so the sample spacing depends only on the clock. In the ready-paced mode, the next conversion starts as soon as the slowest site has answered, so the total time follows the ADCs. After the last sample, a sequential divider forms each site's average. Done rises once the averages are valid. Software then pulls each site's stored samples out in a burst, through a valid/ready stream.

Top module: `isc_sampler`

## Requirements
- R1: When the block is idle and no burst is active, a one-cycle `start` launches a series of exactly N_SAMPLES conversions (1000 by default). Each conversion is a one-cycle `adc_conv` pulse, shared by all sites, so every site converts on the same cycle.
- R2: While a sample is outstanding, each site's `adc_data` is captured on the first cycle in which its `adc_rdy` bit is high. The value is stored in that site's memory at the sample's index, counting from 0.
- R3: In fixed-tick mode (`fixed_mode`=1 at start), successive `adc_conv` pulses are exactly TICK cycles apart (712 by default). This holds whenever every site's ready arrives no later than TICK-1 cycles after the pulse.
- R4: In fixed-tick mode, if any site has not answered by the last cycle of the tick, `overrun` sets. It stays set until the next accepted start clears it. The next pulse then falls on the first tick boundary after the late answer, so the spacing is a whole multiple of TICK.
- R5: In ready-paced mode (`fixed_mode`=0 at start), the next `adc_conv` pulse comes on the cycle after the last outstanding site reports ready. `overrun` is never set in this mode.
- R6: On start, each site's minimum resets to all ones and its maximum and sum reset to zero. At the end, `stat_min`, `stat_max` and `stat_sum` hold the per-site minimum, maximum and sum over all samples. The sum is DW+clog2(N_SAMPLES) bits wide, so it cannot overflow.
- R7: `stat_avg` is floor(sum / N_SAMPLES) for each site. `done` rises only once every average is valid, with `busy` low, and it stays high until the next accepted start.
- R8: A `start` received while `busy` is high is ignored. The running series, its count and its statistics are unaffected.
- R9: While idle, `rd_req` with `rd_site` opens a burst for that site from address 0. `rd_data` is the stored sample under `rd_valid`. The address advances on `rd_valid && rd_ready`, and `rd_data` holds while `rd_ready` is low. `rd_last` marks address N_SAMPLES-1, and the burst closes after that word is taken.
- R10: An `rd_req` arriving while `busy` is high is ignored. `rd_valid` stays low during the series and after it.
- R11: After reset, `busy`, `done`, `overrun`, `adc_conv` and `rd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a sampling series |
| fixed_mode | input | 1 | 1: fixed-tick pacing, 0: ready-paced; taken at start |
| adc_conv | output | 1 | Convert pulse to every site ADC |
| adc_rdy | input | N_SITES | Per-site conversion-complete strobe |
| adc_data | input | N_SITES*DW | Per-site conversion result, site s at bits s*DW |
| busy | output | 1 | Series or averaging in progress |
| done | output | 1 | Series finished, statistics valid |
| overrun | output | 1 | Sticky late-ready flag in fixed-tick mode |
| stat_min | output | N_SITES*DW | Per-site minimum |
| stat_max | output | N_SITES*DW | Per-site maximum |
| stat_sum | output | N_SITES*SUM_W | Per-site sum |
| stat_avg | output | N_SITES*DW | Per-site average |
| rd_req | input | 1 | Open a readout burst |
| rd_site | input | SITE_W | Site selected for readout |
| rd_ready | input | 1 | Readout consumer ready |
| rd_valid | output | 1 | Readout word valid |
| rd_data | output | DW | Readout sample |
| rd_last | output | 1 | Final word of the burst |

## Verification
A wrong tick counter or a wrong pacing decision shows up on the next `adc_conv` pulse. Its distance from the previous pulse differs from TICK, from a TICK multiple, or from the slowest latency plus one, so the error appears within one sample period. A capture or index fault corrupts the stored series, so the burst readout of every address exposes it. Broken minimum, maximum or sum state appears when `done` rises, and a divider fault appears in `stat_avg` on that same cycle. A lost clear of `overrun` or `done` is visible on the cycle after the next start.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_GAP,
    ST_DGO,
    ST_DIV
  } seq_st_e;
endpackage

// File: rtl/isc_div.sv
module isc_div #(
  parameter int W       = 22,
  parameter int QW      = 12,
  parameter int DIVISOR = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  dividend,
  output logic          busy,
  output logic [QW-1:0] quo
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W:0] DV = (W+1)'(DIVISOR);

  logic [W-1:0]  dvd_q, rem_q;
  logic [QW-1:0] quo_q;
  logic [CW-1:0] left_q;
  logic          run_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem_q, dvd_q[W-1]};
  assign fits  = trial >= DV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
    end else if (go) begin
      dvd_q  <= dividend;
      rem_q  <= '0;
      quo_q  <= '0;
      left_q <= CW'(W);
      run_q  <= 1'b1;
    end else if (run_q) begin
      dvd_q  <= {dvd_q[W-2:0], 1'b0};
      rem_q  <= fits ? W'(trial - DV) : W'(trial);
      quo_q  <= {quo_q[QW-2:0], fits};
      left_q <= left_q - 1'b1;
      if (left_q == CW'(1)) run_q <= 1'b0;
    end
  end

  assign busy = run_q;
  assign quo  = quo_q;
endmodule

// File: rtl/isc_site.sv
module isc_site #(
  parameter int DW        = 12,
  parameter int N_SAMPLES = 1000,
  parameter int SUM_W     = 22,
  parameter int IDX_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    din,
  input  logic             div_go,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [DW-1:0]    mn,
  output logic [DW-1:0]    mx,
  output logic [SUM_W-1:0] sum,
  output logic [DW-1:0]    avg,
  output logic             div_busy,
  output logic [DW-1:0]    rd_data
);
  function automatic logic [DW-1:0] lower(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (b < a) ? b : a;
  endfunction

  function automatic logic [DW-1:0] higher(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (b > a) ? b : a;
  endfunction

  function automatic logic [SUM_W-1:0] accum(input logic [SUM_W-1:0] s, input logic [DW-1:0] d);
    return s + SUM_W'(d);
  endfunction

  logic [DW-1:0]    mem [N_SAMPLES];
  logic [DW-1:0]    mn_q, mx_q;
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (take) mem[idx] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mn_q  <= '1;
      mx_q  <= '0;
      sum_q <= '0;
    end else if (init) begin
      mn_q  <= '1;
      mx_q  <= '0;
      sum_q <= '0;
    end else if (take) begin
      mn_q  <= lower(mn_q, din);
      mx_q  <= higher(mx_q, din);
      sum_q <= accum(sum_q, din);
    end
  end

  isc_div #(.W(SUM_W), .QW(DW), .DIVISOR(N_SAMPLES)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (sum_q),
    .busy     (div_busy),
    .quo      (avg)
  );

  assign mn      = mn_q;
  assign mx      = mx_q;
  assign sum     = sum_q;
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/isc_sampler.sv
module isc_sampler
  import isc_pkg::*;
#(
  parameter  int N_SITES   = 2,
  parameter  int N_SAMPLES = 1000,
  parameter  int TICK      = 712,
  parameter  int DW        = 12,
  localparam int SUM_W     = DW + $clog2(N_SAMPLES),
  localparam int SITE_W    = (N_SITES > 1) ? $clog2(N_SITES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     fixed_mode,
  output logic                     adc_conv,
  input  logic [N_SITES-1:0]       adc_rdy,
  input  logic [N_SITES*DW-1:0]    adc_data,
  output logic                     busy,
  output logic                     done,
  output logic                     overrun,
  output logic [N_SITES*DW-1:0]    stat_min,
  output logic [N_SITES*DW-1:0]    stat_max,
  output logic [N_SITES*SUM_W-1:0] stat_sum,
  output logic [N_SITES*DW-1:0]    stat_avg,
  input  logic                     rd_req,
  input  logic [SITE_W-1:0]        rd_site,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_last
);
  localparam int IDX_W = $clog2(N_SAMPLES);
  localparam int CNT_W = (TICK > 1) ? $clog2(TICK) : 1;

  seq_st_e            state_q;
  logic [IDX_W-1:0]   idx_q, rd_addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               mode_q, overrun_q, done_q;
  logic [N_SITES-1:0] got_q, take, div_busy;
  logic               rd_act_q;
  logic [SITE_W-1:0]  rd_sel_q;
  logic [DW-1:0]      site_rd [N_SITES];

  // named events shared with the checker
  logic in_wait, sample_done, tick_end, seq_last, ovr_evt, start_ok, div_go, divs_idle;

  assign in_wait     = (state_q == ST_WAIT);
  assign take        = adc_rdy & ~got_q & {N_SITES{in_wait}};
  assign sample_done = in_wait && (&(got_q | take));
  assign tick_end    = (cnt_q == CNT_W'(TICK - 1));
  assign seq_last    = (idx_q == IDX_W'(N_SAMPLES - 1));
  assign ovr_evt     = in_wait && mode_q && tick_end && !sample_done;
  assign start_ok    = start && (state_q == ST_IDLE) && !rd_act_q;
  assign div_go      = (state_q == ST_DGO);
  assign divs_idle   = ~|div_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      mode_q    <= 1'b0;
      got_q     <= '0;
      overrun_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (start_ok) begin
        cnt_q     <= '0;
        idx_q     <= '0;
        mode_q    <= fixed_mode;
        overrun_q <= 1'b0;
        done_q    <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        cnt_q <= tick_end ? '0 : cnt_q + 1'b1;
      end
      if (sample_done && !seq_last) idx_q <= idx_q + 1'b1;
      if (ovr_evt) overrun_q <= 1'b1;
      got_q <= (state_q == ST_CONV) ? '0 : (got_q | take);

      unique case (state_q)
        ST_IDLE: if (start_ok) state_q <= ST_CONV;
        ST_CONV: state_q <= ST_WAIT;
        ST_WAIT: if (sample_done) begin
          if (seq_last)                  state_q <= ST_DGO;
          else if (!mode_q || tick_end)  state_q <= ST_CONV;
          else                           state_q <= ST_GAP;
        end
        ST_GAP:  if (tick_end) state_q <= ST_CONV;
        ST_DGO:  state_q <= ST_DIV;
        ST_DIV:  if (divs_idle) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q  <= 1'b0;
      rd_sel_q  <= '0;
      rd_addr_q <= '0;
    end else if (rd_act_q) begin
      if (rd_ready) begin
        if (rd_addr_q == IDX_W'(N_SAMPLES - 1)) rd_act_q <= 1'b0;
        else rd_addr_q <= rd_addr_q + 1'b1;
      end
    end else if (rd_req && state_q == ST_IDLE) begin
      rd_act_q  <= 1'b1;
      rd_sel_q  <= rd_site;
      rd_addr_q <= '0;
    end
  end

  for (genvar s = 0; s < N_SITES; s++) begin : g_site
    isc_site #(.DW(DW), .N_SAMPLES(N_SAMPLES), .SUM_W(SUM_W), .IDX_W(IDX_W)) u_site (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (start_ok),
      .take     (take[s]),
      .idx      (idx_q),
      .din      (adc_data[s*DW +: DW]),
      .div_go   (div_go),
      .rd_addr  (rd_addr_q),
      .mn       (stat_min[s*DW +: DW]),
      .mx       (stat_max[s*DW +: DW]),
      .sum      (stat_sum[s*SUM_W +: SUM_W]),
      .avg      (stat_avg[s*DW +: DW]),
      .div_busy (div_busy[s]),
      .rd_data  (site_rd[s])
    );
  end

  assign adc_conv = (state_q == ST_CONV);
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign overrun  = overrun_q;
  assign rd_valid = rd_act_q;
  assign rd_data  = site_rd[rd_sel_q];
  assign rd_last  = rd_act_q && (rd_addr_q == IDX_W'(N_SAMPLES - 1));
endmodule

// File: rtl/isc_sampler_chk.sv
module isc_sampler_chk #(
  parameter int N_SITES = 2,
  parameter int TICK    = 712,
  parameter int DW      = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  adc_conv,
  input logic                  busy,
  input logic                  done,
  input logic                  overrun,
  input logic                  mode_q,
  input logic                  ovr_evt,
  input logic                  rd_valid,
  input logic                  rd_ready,
  input logic [DW-1:0]         rd_data,
  input logic [N_SITES*DW-1:0] stat_min,
  input logic [N_SITES*DW-1:0] stat_max
);
  int   gap_q;
  logic seen_q, late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
      late_q <= 1'b0;
    end else begin
      gap_q  <= adc_conv ? 0 : ((gap_q < TICK * 4) ? gap_q + 1 : gap_q);
      seen_q <= busy && (seen_q || adc_conv);
      late_q <= adc_conv ? 1'b0 : (late_q || ovr_evt);
    end
  end

  a_r3_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_conv && seen_q && mode_q && !late_q) |-> (gap_q == TICK - 1));

  a_r1_conv_in_series: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> busy);

  a_r1_series_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r4_overrun_fixed_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> mode_q);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  for (genvar s = 0; s < N_SITES; s++) begin : g_ord
    a_r6_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (stat_min[s*DW +: DW] <= stat_max[s*DW +: DW]));
  end
endmodule

bind isc_sampler isc_sampler_chk #(.N_SITES(N_SITES), .TICK(TICK), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .adc_conv (adc_conv),
  .busy     (busy),
  .done     (done),
  .overrun  (overrun),
  .mode_q   (mode_q),
  .ovr_evt  (ovr_evt),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .stat_min (stat_min),
  .stat_max (stat_max)
);

// File: tb/tb_isc_sampler.sv
module tb_isc_sampler;
  localparam int NS    = 2;
  localparam int NSMP  = 16;
  localparam int TK    = 40;
  localparam int DW    = 12;
  localparam int SUM_W = DW + $clog2(NSMP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, fixed_mode = 1'b0, rd_req = 1'b0, rd_ready = 1'b0;
  logic [0:0] rd_site = '0;
  logic [NS-1:0] adc_rdy = '0;
  logic [NS*DW-1:0] adc_data = '0;
  logic adc_conv, busy, done, overrun, rd_valid, rd_last;
  logic [NS*DW-1:0] stat_min, stat_max, stat_avg;
  logic [NS*SUM_W-1:0] stat_sum;
  logic [DW-1:0] rd_data;

  always #5 clk = ~clk;

  isc_sampler #(.N_SITES(NS), .N_SAMPLES(NSMP), .TICK(TK), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fixed_mode(fixed_mode),
    .adc_conv(adc_conv), .adc_rdy(adc_rdy), .adc_data(adc_data),
    .busy(busy), .done(done), .overrun(overrun),
    .stat_min(stat_min), .stat_max(stat_max), .stat_sum(stat_sum), .stat_avg(stat_avg),
    .rd_req(rd_req), .rd_site(rd_site), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural ADC and sequence model
  int     run_id = 0, base = 0, conv_total = 0, lmax_prev = 0;
  bit     mode_b = 1'b0;
  longint cyc = 0, last_conv = 0;
  int     cd [NS];
  int     pend [NS];
  int     exp_mem [NS][NSMP];

  function automatic int lat_of(input int run, input int s, input int k);
    if (run == 2) return 1 + ((k * 7 + s * 3) % 9);
    if (run == 1 && s == 1 && k == 5) return TK + 3;
    if (run == 0 && s == 0 && k == 7) return TK - 1;
    return 5 + s * 3 + (k % 4);
  endfunction

  function automatic int data_of(input int run, input int s, input int k);
    if (run == 0 && k == 3) return (s == 0) ? 0 : 4095;
    return (run * 911 + s * 577 + k * 1237 + k * k * 31) % 4096;
  endfunction

  initial for (int s = 0; s < NS; s++) cd[s] = 0;

  always @(negedge clk) begin
    int k, gexp;
    string tag;
    cyc++;
    for (int s = 0; s < NS; s++) begin
      adc_rdy[s] = 1'b0;
      if (cd[s] > 0) begin
        cd[s]--;
        if (cd[s] == 0) begin
          adc_rdy[s] = 1'b1;
          adc_data[s*DW +: DW] = DW'(pend[s]);
        end
      end
    end
    if (busy) chk(!rd_valid, "R10", rd_valid, 0);
    if (adc_conv) begin
      k = conv_total - base;
      if (k > 0) begin
        if (mode_b) begin
          gexp = TK * (lmax_prev / TK + 1);
          tag  = (lmax_prev >= TK) ? "R4" : "R3";
        end else begin
          gexp = lmax_prev + 1;
          tag  = "R5";
        end
        chk(cyc - last_conv == gexp, tag, cyc - last_conv, gexp);
      end
      lmax_prev = 0;
      for (int s = 0; s < NS; s++) begin
        cd[s]   = lat_of(run_id, s, k);
        pend[s] = data_of(run_id, s, k);
        if (k < NSMP) exp_mem[s][k] = pend[s];
        if (cd[s] > lmax_prev) lmax_prev = cd[s];
      end
      last_conv = cyc;
      conv_total++;
    end
  end

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary_and_end();
  end

  task automatic run_seq(input int run, input bit mode, input bit poke);
    int n, mn, mx, sm;
    run_id = run;
    mode_b = mode;
    base   = conv_total;
    @(negedge clk);
    fixed_mode = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1", busy, 1);
    chk(!done, "R7", done, 0);
    chk(!overrun, "R4", overrun, 0);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 50) begin
        start  = 1'b1;  // R8: ignored while busy
        rd_req = 1'b1;  // R10: ignored while busy
      end else if (poke && n == 51) begin
        start  = 1'b0;
        rd_req = 1'b0;
      end
    end
    chk(done, "R7", done, 1);
    chk(!busy, "R7", busy, 0);
    chk(conv_total - base == NSMP, poke ? "R8" : "R1", conv_total - base, NSMP);
    chk(overrun == (run == 1), mode ? "R4" : "R5", overrun, run == 1);
    for (int s = 0; s < NS; s++) begin
      mn = 4095; mx = 0; sm = 0;
      for (int k = 0; k < NSMP; k++) begin
        if (exp_mem[s][k] < mn) mn = exp_mem[s][k];
        if (exp_mem[s][k] > mx) mx = exp_mem[s][k];
        sm += exp_mem[s][k];
      end
      chk(stat_min[s*DW +: DW] == DW'(mn), "R6", stat_min[s*DW +: DW], mn);
      chk(stat_max[s*DW +: DW] == DW'(mx), "R6", stat_max[s*DW +: DW], mx);
      chk(stat_sum[s*SUM_W +: SUM_W] == SUM_W'(sm), "R6", stat_sum[s*SUM_W +: SUM_W], sm);
      chk(stat_avg[s*DW +: DW] == DW'(sm / NSMP), "R7", stat_avg[s*DW +: DW], sm / NSMP);
    end
    @(negedge clk);
    chk(!rd_valid, "R10", rd_valid, 0);
  endtask

  task automatic burst(input int site, input bit stall);
    int addr, n;
    @(negedge clk);
    rd_site = 1'(site);
    rd_req  = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    addr = 0;
    n = 0;
    while (addr < NSMP && n < 1000) begin
      rd_ready = stall ? (n % 3 != 0) : 1'b1;
      chk(rd_valid, "R9", rd_valid, 1);
      if (rd_valid) begin
        chk(rd_data == DW'(exp_mem[site][addr]), "R2", rd_data, exp_mem[site][addr]);
        chk(rd_last == (addr == NSMP - 1), "R9", rd_last, addr == NSMP - 1);
        if (rd_ready) addr++;
      end
      @(negedge clk);
      n++;
    end
    rd_ready = 1'b0;
    chk(!rd_valid, "R9", rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R11", busy, 0);
    chk(!done, "R11", done, 0);
    chk(!overrun, "R11", overrun, 0);
    chk(!adc_conv, "R11", adc_conv, 0);
    chk(!rd_valid, "R11", rd_valid, 0);

    run_seq(0, 1'b1, 1'b0);   // fixed tick, extremes 0 and 4095, boundary latency
    burst(0, 1'b1);
    burst(1, 1'b0);
    run_seq(1, 1'b1, 1'b0);   // fixed tick with one late site
    burst(1, 1'b1);
    run_seq(2, 1'b0, 1'b1);   // ready-paced, start and rd_req poked mid-series
    burst(0, 1'b0);
    burst(1, 1'b1);
    summary_and_end();
  end
endmodule